// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block watches a set of switching regulators through digital comparator flags and decides when each one may keep running. Every regulator has an enable request from the sequencer, a flag that says its output sits below the short-circuit threshold, and a flag from its current limiter. Two global flags report die over-temperature and supply overvoltage. All timing is measured in pulses of a one-microsecond strobe, `tick_us`, so the block runs on any system clock faster than that strobe.

After a regulator is enabled, a single sample of its low-output flag is taken on the final tick of a fixed check window. If the flag is high then, the fault is a short circuit. Once the check has passed, the regulator is in normal operation, and a low-output flag that holds for a debounce window is an overload. Either fault turns the regulator off and leaves it off until its request is withdrawn and given again. A current limit that holds for its own shorter window only raises an event. Either global flag turns every regulator off and forces all output GPIOs low until both flags are clear.

The event outputs are single-cycle pulses meant for an interrupt controller. They have no handshake. The controller has to capture every pulse it sees.

Top module: `reg_fault_supervisor`

## Requirements
- R1: After reset every `reg_en` bit, `gpio_force_low` and every event output are 0.
- R2: While no fault is latched and no shutdown is active, `reg_en[i]` goes to 1 one clock after `en_req[i]` is sampled high, and goes to 0 one clock after `en_req[i]` is sampled low.
- R3: The short-circuit check samples `out_low[i]` once, on the SC_TICKS-th tick after the regulator is enabled. If it is high on that tick, the regulator latches a fault, `reg_en[i]` drops, and `fault_evt[i]` pulses for one cycle.
- R4: A value of `out_low[i]` on any earlier tick of the check window has no effect. If the final sample is low, the regulator stays enabled and raises no event.
- R5: After the check has passed, `out_low[i]` held high for OL_TICKS consecutive ticks latches an overload fault. This has the same effect as R3. Fewer ticks have no effect.
- R6: If a debounced input (`out_low` during operation, or `ilim`) drops before its window is complete, the count starts again from zero.
- R7: A latched fault keeps `reg_en[i]` at 0, whatever `out_low[i]` does, until `en_req[i]` is sampled low. Raising the request again starts a new short-circuit check.
- R8: `ilim[i]` held high for ILIM_TICKS consecutive ticks while `reg_en[i]` is 1 gives exactly one `ilim_evt[i]` pulse for each continuous assertion. It never changes `reg_en[i]`.
- R9: A rising `therm_sd` gives one `tsd_evt` pulse. While it is high, all `reg_en` bits are 0 and `gpio_force_low` is 1.
- R10: A rising `ovp` gives one `ovp_evt` pulse. While it is high, it has the same effect on `reg_en` and `gpio_force_low` as R9.
- R11: Shutdown is released only when both `therm_sd` and `ovp` are low. Requested regulators without a latched fault then re-enable and each runs a new check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle strobe, once per microsecond |
| en_req | input | NUM_REG | Per-regulator enable request |
| out_low | input | NUM_REG | Output below short-circuit threshold |
| ilim | input | NUM_REG | Current limiter active |
| therm_sd | input | 1 | Die temperature above shutdown level |
| ovp | input | 1 | Supply above overvoltage level |
| reg_en | output | NUM_REG | Gated regulator enables |
| gpio_force_low | output | 1 | Drive output-mode GPIOs low |
| fault_evt | output | NUM_REG | Short-circuit/overload event pulse |
| ilim_evt | output | NUM_REG | Debounced current-limit event pulse |
| tsd_evt | output | 1 | Thermal shutdown event pulse |
| ovp_evt | output | 1 | Overvoltage event pulse |

## Verification
The hardest situation to reach is the exact boundary of each window. The fault must appear on the last tick and never one tick early. A glitch one tick before completion must restart the count. To reach these cases, the bench drives `tick_us` itself, one strobe at a time, with small window parameters. It sweeps the length of the input assertion across every value from zero to past the limit, so the count of tick strobes alone fixes the expected outcome. A second sweep raises `out_low` during the check window and lowers it just before the final sample.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_CHECK = 2'd1,
    CH_RUN   = 2'd2,
    CH_FAULT = 2'd3
  } ch_state_t;

  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/rfs_tick_debounce.sv
module rfs_tick_debounce #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic level,
  input  logic tick,
  output logic fire
);
  localparam int CW = rfs_pkg::cnt_bits(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (clear || !level) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (tick && !done) begin
        if (cnt == LAST) begin
          fire <= 1'b1;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: a fire can only follow a sample where the input was held
  a_r6_fire_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(level) && !$past(clear));
  // R8: one pulse per completed window
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/rfs_global_guard.sv
module rfs_global_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic therm_sd,
  input  logic ovp,
  output logic shutdown,
  output logic tsd_evt,
  output logic ovp_evt
);
  logic therm_prev, ovp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      therm_prev <= 1'b0;
      ovp_prev   <= 1'b0;
      shutdown   <= 1'b0;
      tsd_evt    <= 1'b0;
      ovp_evt    <= 1'b0;
    end else begin
      therm_prev <= therm_sd;
      ovp_prev   <= ovp;
      tsd_evt    <= therm_sd && !therm_prev;
      ovp_evt    <= ovp && !ovp_prev;
      shutdown   <= therm_sd || ovp;
    end
  end

  // R9: a thermal event always comes with an active shutdown
  a_r9_tsd_with_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_evt |-> shutdown);
  // R10: an overvoltage event always comes with an active shutdown
  a_r10_ovp_with_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_evt |-> shutdown);
  // R11: release only after both conditions were seen low
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> !$past(therm_sd) && !$past(ovp));

endmodule

// File: rtl/rfs_reg_channel.sv
module rfs_reg_channel #(
  parameter int SC_TICKS   = 1000,
  parameter int OL_TICKS   = 1000,
  parameter int ILIM_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic shutdown,
  input  logic en_req,
  input  logic out_low,
  input  logic ilim,
  output logic reg_en,
  output logic fault_evt,
  output logic ilim_evt
);
  import rfs_pkg::*;

  localparam int SCW = cnt_bits(SC_TICKS);
  localparam logic [SCW-1:0] SC_LAST = SCW'(SC_TICKS - 1);

  ch_state_t      state;
  logic [SCW-1:0] sc_cnt;
  logic           ol_fire;
  logic           ol_clear;
  logic           il_clear;

  assign reg_en   = (state == CH_CHECK) || (state == CH_RUN);
  assign ol_clear = (state != CH_RUN);
  assign il_clear = !reg_en;

  rfs_tick_debounce #(.LIMIT(OL_TICKS)) u_ol_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (ol_clear),
    .level (out_low),
    .tick  (tick),
    .fire  (ol_fire)
  );

  rfs_tick_debounce #(.LIMIT(ILIM_TICKS)) u_il_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (il_clear),
    .level (ilim),
    .tick  (tick),
    .fire  (ilim_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CH_IDLE;
      sc_cnt    <= '0;
      fault_evt <= 1'b0;
    end else begin
      fault_evt <= 1'b0;
      case (state)
        CH_IDLE: begin
          sc_cnt <= '0;
          if (en_req && !shutdown) state <= CH_CHECK;
        end
        CH_CHECK: begin
          if (!en_req || shutdown) begin
            state <= CH_IDLE;
          end else if (tick) begin
            if (sc_cnt == SC_LAST) begin
              if (out_low) begin
                state     <= CH_FAULT;
                fault_evt <= 1'b1;
              end else begin
                state <= CH_RUN;
              end
            end else begin
              sc_cnt <= sc_cnt + 1'b1;
            end
          end
        end
        CH_RUN: begin
          if (!en_req || shutdown) begin
            state <= CH_IDLE;
          end else if (ol_fire) begin
            state     <= CH_FAULT;
            fault_evt <= 1'b1;
          end
        end
        CH_FAULT: begin
          if (!en_req) state <= CH_IDLE;
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  // R3: every fault event leaves the regulator disabled
  a_r3_evt_disables: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> !reg_en);
  // R7: a latched fault holds the enable low while the request stays
  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en && $past(en_req) && en_req && $past(state == CH_FAULT)) |-> state == CH_FAULT);
  // R9/R10: shutdown turns the output off by the next cycle
  a_r9_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !reg_en);
  // R2: no enable without a request
  a_r2_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> !reg_en);

endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor #(
  parameter int NUM_REG    = 4,
  parameter int SC_TICKS   = 1000,
  parameter int OL_TICKS   = 1000,
  parameter int ILIM_TICKS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_us,
  input  logic [NUM_REG-1:0] en_req,
  input  logic [NUM_REG-1:0] out_low,
  input  logic [NUM_REG-1:0] ilim,
  input  logic               therm_sd,
  input  logic               ovp,
  output logic [NUM_REG-1:0] reg_en,
  output logic               gpio_force_low,
  output logic [NUM_REG-1:0] fault_evt,
  output logic [NUM_REG-1:0] ilim_evt,
  output logic               tsd_evt,
  output logic               ovp_evt
);
  logic shutdown;

  rfs_global_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .therm_sd (therm_sd),
    .ovp      (ovp),
    .shutdown (shutdown),
    .tsd_evt  (tsd_evt),
    .ovp_evt  (ovp_evt)
  );

  assign gpio_force_low = shutdown;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_ch
    rfs_reg_channel #(
      .SC_TICKS   (SC_TICKS),
      .OL_TICKS   (OL_TICKS),
      .ILIM_TICKS (ILIM_TICKS)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_us),
      .shutdown  (shutdown),
      .en_req    (en_req[i]),
      .out_low   (out_low[i]),
      .ilim      (ilim[i]),
      .reg_en    (reg_en[i]),
      .fault_evt (fault_evt[i]),
      .ilim_evt  (ilim_evt[i])
    );
  end

  // R9/R10: outputs forced while shutdown is reported
  a_r10_force_gates_all: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_force_low && $past(gpio_force_low) |-> reg_en == '0);

endmodule

// File: tb/reg_fault_supervisor_bench.sv
module reg_fault_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 2;
  localparam int SC = 10;
  localparam int OL = 8;
  localparam int IL = 4;

  logic clk = 0, rst_n = 0, tick_us = 0, therm_sd = 0, ovp = 0;
  logic [N-1:0] en_req = '0, out_low = '0, ilim = '0;
  logic [N-1:0] reg_en, fault_evt, ilim_evt;
  logic gpio_force_low, tsd_evt, ovp_evt;

  int tests = 0, fails = 0;
  int fcnt [N];
  int icnt [N];
  int tcnt = 0, ocnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_fault_supervisor #(.NUM_REG(N), .SC_TICKS(SC), .OL_TICKS(OL), .ILIM_TICKS(IL))
  u_reg_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_req(en_req),
    .out_low(out_low), .ilim(ilim), .therm_sd(therm_sd), .ovp(ovp),
    .reg_en(reg_en), .gpio_force_low(gpio_force_low), .fault_evt(fault_evt),
    .ilim_evt(ilim_evt), .tsd_evt(tsd_evt), .ovp_evt(ovp_evt));

  initial begin
    for (int i = 0; i < N; i++) begin fcnt[i] = 0; icnt[i] = 0; end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (fault_evt[i]) fcnt[i] = fcnt[i] + 1;
        if (ilim_evt[i])  icnt[i] = icnt[i] + 1;
      end
      if (tsd_evt) tcnt = tcnt + 1;
      if (ovp_evt) ocnt = ocnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_us = 1;
      @(negedge clk); tick_us = 0;
      cycles(3);
    end
  endtask

  // restart a channel and run it through a passing short-circuit check
  task automatic start_run(input int c);
    en_req[c] = 0; out_low[c] = 0; cycles(3);
    en_req[c] = 1; cycles(3);
    ticks(SC);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0, i0, t0, o0;
    cycles(2);
    check("R1 reg_en", int'(reg_en), 0);
    check("R1 force_low", int'(gpio_force_low), 0);
    check("R1 events", int'(fault_evt) + int'(ilim_evt) + int'(tsd_evt) + int'(ovp_evt), 0);
    rst_n = 1; cycles(2);

    // R2: enable follows request
    en_req[0] = 1;
    @(negedge clk);
    @(negedge clk);
    check("R2 enable after request", int'(reg_en[0]), 1);
    check("R2 other channel idle", int'(reg_en[1]), 0);
    en_req[0] = 0;
    @(negedge clk);
    @(negedge clk);
    check("R2 disable after drop", int'(reg_en[0]), 0);

    // R3: persistent low output -> short circuit on the last tick only
    f0 = fcnt[0];
    out_low[0] = 1; en_req[0] = 1; cycles(3);
    ticks(SC - 1);
    check("R3 no fault before last tick", fcnt[0] - f0, 0);
    check("R3 still enabled before last tick", int'(reg_en[0]), 1);
    ticks(1);
    check("R3 fault event", fcnt[0] - f0, 1);
    check("R3 disabled", int'(reg_en[0]), 0);

    // R7: latched until request cycled
    out_low[0] = 0; ticks(OL + 2);
    check("R7 latched", int'(reg_en[0]), 0);
    en_req[0] = 0; cycles(3); en_req[0] = 1; cycles(3);
    check("R7 re-enabled", int'(reg_en[0]), 1);
    ticks(SC);
    check("R7 new check passed", int'(reg_en[0]), 1);

    // R4: low output on each earlier check tick only is ignored
    for (int p = 0; p < SC - 1; p++) begin
      f0 = fcnt[0];
      en_req[0] = 0; out_low[0] = 0; cycles(3); en_req[0] = 1; cycles(3);
      ticks(p);
      out_low[0] = 1; ticks(SC - 1 - p);
      out_low[0] = 0; ticks(1);
      check("R4 early samples ignored", fcnt[0] - f0, 0);
      check("R4 remains enabled", int'(reg_en[0]), 1);
    end

    // R5: overload debounce sweep
    for (int k = 0; k <= OL + 1; k++) begin
      start_run(0);
      f0 = fcnt[0];
      out_low[0] = 1; ticks(k); out_low[0] = 0;
      check("R5 overload event", fcnt[0] - f0, (k >= OL) ? 1 : 0);
      check("R5 overload enable", int'(reg_en[0]), (k >= OL) ? 0 : 1);
    end

    // R6: overload count restarts after a dropout
    start_run(0);
    f0 = fcnt[0];
    out_low[0] = 1; ticks(OL - 1);
    out_low[0] = 0; ticks(1);
    out_low[0] = 1; ticks(OL - 1);
    check("R6 overload restart", fcnt[0] - f0, 0);
    ticks(1);
    check("R6 overload after full window", fcnt[0] - f0, 1);
    out_low[0] = 0;

    // R8: current-limit sweep on channel 1
    start_run(1);
    for (int k = 0; k <= IL + 2; k++) begin
      i0 = icnt[1];
      ilim[1] = 1; ticks(k); ilim[1] = 0; ticks(1);
      check("R8 ilim event", icnt[1] - i0, (k >= IL) ? 1 : 0);
      check("R8 ilim no disable", int'(reg_en[1]), 1);
    end
    // R6: current-limit restart
    i0 = icnt[1];
    ilim[1] = 1; ticks(IL - 1); ilim[1] = 0; ticks(1);
    ilim[1] = 1; ticks(IL - 1);
    check("R6 ilim restart", icnt[1] - i0, 0);
    ticks(1); ilim[1] = 0;
    check("R6 ilim after full window", icnt[1] - i0, 1);

    // R9/R10/R11: global shutdown
    start_run(0);
    t0 = tcnt; o0 = ocnt;
    therm_sd = 1; cycles(3);
    check("R9 all off", int'(reg_en), 0);
    check("R9 force low", int'(gpio_force_low), 1);
    ticks(3);
    check("R9 one thermal event", tcnt - t0, 1);
    ovp = 1; cycles(3);
    check("R10 ovp event", ocnt - o0, 1);
    therm_sd = 0; cycles(3);
    check("R11 held by ovp", int'(gpio_force_low), 1);
    check("R11 still off", int'(reg_en), 0);
    ovp = 0; cycles(3);
    check("R11 released", int'(gpio_force_low), 0);
    check("R11 restart both", int'(reg_en), 3);
    ticks(SC);
    check("R11 new check passes", int'(reg_en), 3);

    // R10 alone
    o0 = ocnt; t0 = tcnt;
    ovp = 1; cycles(3);
    check("R10 all off", int'(reg_en), 0);
    check("R10 force low", int'(gpio_force_low), 1);
    check("R10 no thermal event", tcnt - t0, 0);
    ovp = 0; cycles(3);
    check("R10 one event", ocnt - o0, 1);
    check("R11 release after ovp", int'(reg_en), 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule